// File: doc/BRIEF.md
# Sector ECC Syndrome Classifier and Bit Fixer

This block runs after a flash page has been read into a sector buffer. For each sector it takes the parity code that was stored with the data and the code that was recomputed while the data was read. It XORs the two codes into a syndrome and counts the ones in it. From that count it decides whether the sector is clean, holds one flipped data bit, has a damaged stored code, or has more errors than it can repair. The sector size mode sets the count that marks a single-bit error and where the error location sits inside the syndrome.

A job begins with a one-cycle `start`, which also supplies the mode and the number of sectors. The block walks the sectors in ascending order. On `code_sel` it names the sector whose two codes must be on `stored_code` and `calc_code` in the same cycle. When a sector has a single-bit error, the block reads the faulty byte from the buffer and writes it back one cycle later with that bit inverted. An error that cannot be repaired, or a damaged code, ends the job at once. When the job ends, `done` pulses and `status` gives the result for the whole page. The most recent repair location stays on `fix_addr`/`fix_bit`.

Top module: `ecc_sector_fixer`

## Requirements
- R1: The syndrome is `stored_code ^ calc_code`. An all-zero syndrome classifies the sector as clean, and a clean sector causes no buffer access.
- R2: In mode 0 (256-byte sectors), a syndrome with exactly 11 ones is a single-bit error. The byte offset is `{syn[10:8], syn[7:3]}`, the bit number is `syn[2:0]`, and the buffer address is sector×256 + offset.
- R3: In mode 1 (512-byte sectors), exactly 12 ones is a single-bit error. The byte offset is `{syn[11:8], syn[7:3]}`, the bit number is `syn[2:0]`, and the address is sector×512 + offset.
- R4: Modes 2 and 3 (whole page, 16-bit words) check only sector 0, whatever `sect_cnt` holds. Exactly 15 ones is a single-bit error. The word index is `syn[15:4]` and the word bit is `syn[3:0]`. The byte address is 2×word + `syn[3]`, and the bit within that byte is `syn[2:0]`.
- R5: A syndrome with exactly one bit set gives status 2 (stored code damaged), and the buffer is not written.
- R6: Every other nonzero count gives status 3 (uncorrectable). This includes a count that marks a single-bit error only in a different mode.
- R7: Sectors 0 to `sect_cnt` are checked in ascending order, so `sect_cnt` holds the count minus one. A status 2 or status 3 result ends the job immediately, and later sectors are neither examined nor written.
- R8: If the job had at least one correction and no abort, the page status is 1. Otherwise a job without errors reports 0. `fix_addr`/`fix_bit` show the most recent correction, and an abort that follows a correction leaves them unchanged.
- R9: A correction reads the byte at its address. In the next cycle it writes the same address with the read value XOR a one-hot mask at the bit number. Each correction produces exactly one write.
- R10: `done` is high for exactly one cycle. `status` holds its value until the next job ends. `done` rises S+2C cycles after the edge that samples `start`, where S is the number of sectors examined and C the number of corrections.
- R11: A `start` that arrives while a job is running is ignored. The running job is unaffected and produces only one `done`.
- R12: After reset, `done`, `status`, `buf_rd_en` and `buf_wr_en` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle job start, sampled only when idle |
| mode | input | 2 | 0: 256-byte sectors, 1: 512-byte sectors, 2/3: whole page |
| sect_cnt | input | SCNT_W (4) | Number of sectors minus one |
| code_sel | output | SCNT_W (4) | Sector whose codes must be presented this cycle |
| stored_code | input | CODE_W (32) | Code read from flash for the selected sector |
| calc_code | input | CODE_W (32) | Code recomputed for the selected sector |
| buf_rd_en | output | 1 | Sector buffer read strobe (data returns next cycle) |
| buf_wr_en | output | 1 | Sector buffer write strobe |
| buf_addr | output | ADDR_W (13) | Sector buffer byte address |
| buf_rd_data | input | 8 | Read data, one cycle after `buf_rd_en` |
| buf_wr_data | output | 8 | Corrected byte |
| done | output | 1 | Job finished pulse |
| status | output | 2 | 0 clean, 1 corrected, 2 code damaged, 3 uncorrectable |
| fix_addr | output | ADDR_W (13) | Buffer byte address of the most recent correction |
| fix_bit | output | 3 | Bit within that byte |

## Verification
The bench places single-bit errors so that the offset field's upper bits land above bit 7: syndrome bit 11 in 512-byte mode, and the odd byte of a word in page mode. A design that dropped the extra offset bit, or used the wrong word/byte mapping, would write a byte that was never bad. It also feeds an 11-one syndrome in 512-byte mode, which must be reported as uncorrectable and not repaired at a wrong place. A further case puts a multi-bit sector ahead of a correctable one; a design that kept going after the abort would produce a buffer write. Other cases check a page-mode job with junk codes in the later sectors, a correction followed by an abort, and a stray `start` in the middle of a job. Each of these would show up as a wrong status, an extra `done`, or a latency other than S+2C.

// File: rtl/ecc_fix_pkg.sv
package ecc_fix_pkg;

   typedef enum logic [1:0] {
      EST_CLEAN = 2'd0,
      EST_FIXED = 2'd1,
      EST_CODE  = 2'd2,
      EST_MULTI = 2'd3
   } ecc_stat_e;

   typedef enum logic [1:0] {
      EMD_S256  = 2'd0,
      EMD_S512  = 2'd1,
      EMD_PAGE  = 2'd2,
      EMD_PAGE2 = 2'd3
   } ecc_mode_e;

   typedef enum logic [1:0] {
      SQ_IDLE  = 2'd0,
      SQ_CHECK = 2'd1,
      SQ_FIX   = 2'd2
   } seq_state_e;

   // ones in the syndrome that mark a single flipped data bit
   localparam int ONES_S256 = 11;
   localparam int ONES_S512 = 12;
   localparam int ONES_PAGE = 15;

   localparam int SHIFT_S256 = 8;
   localparam int SHIFT_S512 = 9;

endpackage

// File: rtl/ecc_syn_classify.sv
module ecc_syn_classify
   import ecc_fix_pkg::*;
#(
   parameter int CODE_W = 32,
   parameter int ADDR_W = 13
) (
   input  logic [CODE_W-1:0] syn,
   input  ecc_mode_e         mode,
   output ecc_stat_e         cls,
   output logic [ADDR_W-1:0] off,
   output logic [2:0]        bit_idx
);

   localparam int CNT_W = $clog2(CODE_W + 1);

   logic [CNT_W-1:0] ones;
   logic [CNT_W-1:0] target;

   // population count of the syndrome
   always_comb begin
      ones = '0;
      for (int i = 0; i < CODE_W; i++) begin
         ones = ones + CNT_W'(syn[i]);
      end
   end

   always_comb begin
      unique case (mode)
         EMD_S256: target = CNT_W'(ONES_S256);
         EMD_S512: target = CNT_W'(ONES_S512);
         default:  target = CNT_W'(ONES_PAGE);
      endcase
   end

   always_comb begin
      if (syn == '0)            cls = EST_CLEAN;
      else if (ones == target)  cls = EST_FIXED;
      else if (ones == CNT_W'(1)) cls = EST_CODE;
      else                      cls = EST_MULTI;
   end

   // location fields; in page mode the word bit [3] selects the odd byte
   always_comb begin
      unique case (mode)
         EMD_S256: off = ADDR_W'({syn[10:8], syn[7:3]});
         EMD_S512: off = ADDR_W'({syn[11:8], syn[7:3]});
         default:  off = ADDR_W'({syn[15:4], syn[3]});
      endcase
      bit_idx = syn[2:0];
   end

endmodule

// File: rtl/ecc_rmw_port.sv
module ecc_rmw_port #(
   parameter int ADDR_W = 13,
   parameter int DATA_W = 8,
   localparam int BIT_W = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic [BIT_W-1:0]  bit_in,
   input  logic [DATA_W-1:0] rd_data,
   output logic              rd_en,
   output logic              wr_en,
   output logic [ADDR_W-1:0] addr,
   output logic [DATA_W-1:0] wr_data,
   output logic              fin
);

   logic phase_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   phase_q <= 1'b0;
      else if (go)  phase_q <= ~phase_q;
      else          phase_q <= 1'b0;
   end

   logic [DATA_W-1:0] mask;
   always_comb begin
      mask = '0;
      mask[bit_in] = 1'b1;
   end

   assign rd_en   = go & ~phase_q;
   assign wr_en   = go & phase_q;
   assign fin     = wr_en;
   assign addr    = addr_in;
   assign wr_data = rd_data ^ mask;

   // R9
   wr_after_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> $past(rd_en));

   // R9
   wr_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (addr == $past(addr)));

endmodule

// File: rtl/ecc_page_seq.sv
module ecc_page_seq
   import ecc_fix_pkg::*;
#(
   parameter int  SCNT_W = 4,
   parameter int  ADDR_W = 13,
   parameter bit  FIX_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [1:0]        mode_in,
   input  logic [SCNT_W-1:0] sect_cnt,
   input  ecc_stat_e         cls,
   input  logic [ADDR_W-1:0] off,
   input  logic [2:0]        bit_idx,
   input  logic              rmw_fin,
   output logic [SCNT_W-1:0] code_sel,
   output ecc_mode_e         mode_q,
   output logic              rmw_go,
   output logic [ADDR_W-1:0] fix_addr,
   output logic [2:0]        fix_bit,
   output logic              done,
   output logic [1:0]        status
);

   seq_state_e        state;
   logic [SCNT_W-1:0] sec_q;
   logic [SCNT_W-1:0] last_q;
   logic              fixed_q;
   logic              done_q;
   ecc_stat_e         stat_q;
   logic [ADDR_W-1:0] base;
   logic              last_sec;

   always_comb begin
      unique case (mode_q)
         EMD_S256: base = ADDR_W'(sec_q) << SHIFT_S256;
         EMD_S512: base = ADDR_W'(sec_q) << SHIFT_S512;
         default:  base = '0;
      endcase
   end

   assign last_sec = (sec_q == last_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= SQ_IDLE;
         sec_q    <= '0;
         last_q   <= '0;
         mode_q   <= EMD_S256;
         fixed_q  <= 1'b0;
         done_q   <= 1'b0;
         stat_q   <= EST_CLEAN;
         fix_addr <= '0;
         fix_bit  <= '0;
      end else begin
         done_q <= 1'b0;
         unique case (state)
            SQ_IDLE: begin
               if (start) begin
                  mode_q  <= ecc_mode_e'(mode_in);
                  last_q  <= (mode_in[1]) ? '0 : sect_cnt;
                  sec_q   <= '0;
                  fixed_q <= 1'b0;
                  state   <= SQ_CHECK;
               end
            end
            SQ_CHECK: begin
               unique case (cls)
                  EST_CLEAN: begin
                     if (last_sec) begin
                        done_q <= 1'b1;
                        stat_q <= fixed_q ? EST_FIXED : EST_CLEAN;
                        state  <= SQ_IDLE;
                     end else begin
                        sec_q <= sec_q + 1'b1;
                     end
                  end
                  EST_FIXED: begin
                     fix_addr <= base + off;
                     fix_bit  <= bit_idx;
                     fixed_q  <= 1'b1;
                     if (FIX_EN) begin
                        state <= SQ_FIX;
                     end else if (last_sec) begin
                        done_q <= 1'b1;
                        stat_q <= EST_FIXED;
                        state  <= SQ_IDLE;
                     end else begin
                        sec_q <= sec_q + 1'b1;
                     end
                  end
                  default: begin
                     done_q <= 1'b1;
                     stat_q <= cls;
                     state  <= SQ_IDLE;
                  end
               endcase
            end
            SQ_FIX: begin
               if (rmw_fin) begin
                  if (last_sec) begin
                     done_q <= 1'b1;
                     stat_q <= EST_FIXED;
                     state  <= SQ_IDLE;
                  end else begin
                     sec_q <= sec_q + 1'b1;
                     state <= SQ_CHECK;
                  end
               end
            end
            default: state <= SQ_IDLE;
         endcase
      end
   end

   assign code_sel = sec_q;
   assign rmw_go   = (state == SQ_FIX);
   assign done     = done_q;
   assign status   = stat_q;

   // R10
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R7
   abort_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SQ_CHECK && (cls == EST_CODE || cls == EST_MULTI))
      |=> (done && status == $past(cls)));

   // R7
   sector_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SQ_CHECK && cls == EST_CLEAN && !last_sec)
      |=> (code_sel == $past(code_sel) + 1'b1));

endmodule

// File: rtl/ecc_sector_fixer.sv
module ecc_sector_fixer
   import ecc_fix_pkg::*;
#(
   parameter int  MAX_SECT = 16,
   parameter int  CODE_W   = 32,
   parameter bit  FIX_EN   = 1'b1,
   localparam int SCNT_W   = (MAX_SECT > 1) ? $clog2(MAX_SECT) : 1,
   localparam int SPAN_W   = $clog2(MAX_SECT * 512),
   localparam int ADDR_W   = (SPAN_W > 13) ? SPAN_W : 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [1:0]        mode,
   input  logic [SCNT_W-1:0] sect_cnt,
   output logic [SCNT_W-1:0] code_sel,
   input  logic [CODE_W-1:0] stored_code,
   input  logic [CODE_W-1:0] calc_code,
   output logic              buf_rd_en,
   output logic              buf_wr_en,
   output logic [ADDR_W-1:0] buf_addr,
   input  logic [7:0]        buf_rd_data,
   output logic [7:0]        buf_wr_data,
   output logic              done,
   output logic [1:0]        status,
   output logic [ADDR_W-1:0] fix_addr,
   output logic [2:0]        fix_bit
);

   if (CODE_W < 31) begin : g_bad_code_w
      $error("CODE_W must hold the page-mode code (31 bits or more)");
   end
   if (MAX_SECT < 1 || (MAX_SECT & (MAX_SECT - 1)) != 0) begin : g_bad_sect
      $error("MAX_SECT must be a power of two");
   end

   ecc_stat_e         cls;
   ecc_mode_e         mode_q;
   logic [ADDR_W-1:0] off;
   logic [2:0]        bit_idx;
   logic              rmw_go;
   logic              rmw_fin;

   ecc_syn_classify #(.CODE_W(CODE_W), .ADDR_W(ADDR_W)) u_cls (
      .syn     (stored_code ^ calc_code),
      .mode    (mode_q),
      .cls     (cls),
      .off     (off),
      .bit_idx (bit_idx)
   );

   ecc_page_seq #(.SCNT_W(SCNT_W), .ADDR_W(ADDR_W), .FIX_EN(FIX_EN)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .mode_in  (mode),
      .sect_cnt (sect_cnt),
      .cls      (cls),
      .off      (off),
      .bit_idx  (bit_idx),
      .rmw_fin  (rmw_fin),
      .code_sel (code_sel),
      .mode_q   (mode_q),
      .rmw_go   (rmw_go),
      .fix_addr (fix_addr),
      .fix_bit  (fix_bit),
      .done     (done),
      .status   (status)
   );

   if (FIX_EN) begin : g_rmw
      ecc_rmw_port #(.ADDR_W(ADDR_W), .DATA_W(8)) u_rmw (
         .clk     (clk),
         .rst_n   (rst_n),
         .go      (rmw_go),
         .addr_in (fix_addr),
         .bit_in  (fix_bit),
         .rd_data (buf_rd_data),
         .rd_en   (buf_rd_en),
         .wr_en   (buf_wr_en),
         .addr    (buf_addr),
         .wr_data (buf_wr_data),
         .fin     (rmw_fin)
      );
   end else begin : g_report_only
      assign buf_rd_en   = 1'b0;
      assign buf_wr_en   = 1'b0;
      assign buf_addr    = '0;
      assign buf_wr_data = '0;
      assign rmw_fin     = 1'b0;
   end

   // R12
   rst_quiet_chk: assert property (@(posedge clk)
      !rst_n |-> (!done && !buf_rd_en && !buf_wr_en));

endmodule

// File: tb/ecc_sector_fixer_test.sv
module ecc_sector_fixer_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [1:0]  mode_r = 2'd0;
   logic [3:0]  cnt_r = 4'd0;
   logic [3:0]  code_sel;
   logic [31:0] stored_code, calc_code;
   logic        buf_rd_en, buf_wr_en;
   logic [12:0] buf_addr;
   logic [7:0]  buf_rd_data = 8'h00;
   logic [7:0]  buf_wr_data;
   logic        done;
   logic [1:0]  status;
   logic [12:0] fix_addr;
   logic [2:0]  fix_bit;

   always #4 clk = ~clk;

   ecc_sector_fixer uut (
      .clk(clk), .rst_n(rst_n), .start(start), .mode(mode_r), .sect_cnt(cnt_r),
      .code_sel(code_sel), .stored_code(stored_code), .calc_code(calc_code),
      .buf_rd_en(buf_rd_en), .buf_wr_en(buf_wr_en), .buf_addr(buf_addr),
      .buf_rd_data(buf_rd_data), .buf_wr_data(buf_wr_data), .done(done),
      .status(status), .fix_addr(fix_addr), .fix_bit(fix_bit)
   );

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int start_cyc = 0;
   int wr_total = 0;
   int wr_base = 0;
   int seen = 0;
   bit finished = 1'b0;

   logic [31:0] st_arr [16];
   logic [31:0] syn_arr [16];
   assign stored_code = st_arr[code_sel];
   assign calc_code   = st_arr[code_sel] ^ syn_arr[code_sel];

   logic [7:0] wmem [int];

   function automatic logic [7:0] pat(int a);
      return 8'(a) ^ 8'hA5 ^ 8'(a >> 8);
   endfunction

   function automatic logic [7:0] memrd(int a);
      if (wmem.exists(a)) return wmem[a];
      return pat(a);
   endfunction

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (buf_rd_en) buf_rd_data <= memrd(int'(buf_addr));
      if (buf_wr_en) begin
         wmem[int'(buf_addr)] = buf_wr_data;
         wr_total <= wr_total + 1;
      end
   end

   typedef struct {
      int    stat;
      int    addr;
      int    bitn;
      int    writes;
      int    lat;
      bit    chk_loc;
      string req;
   } exp_t;
   exp_t sbq[$];

   task automatic chk(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin : mon
      exp_t e;
      if (rst_n && done) begin
         if (sbq.size() == 0) begin
            chk(1'b0, "R11 unexpected done", 1, 0);
         end else begin
            e = sbq.pop_front();
            chk(int'(status) == e.stat, {e.req, " status"}, int'(status), e.stat);
            chk((wr_total - wr_base) == e.writes, {e.req, " writes"}, wr_total - wr_base, e.writes);
            chk((cyc - start_cyc) == e.lat, "R10 latency", cyc - start_cyc, e.lat);
            if (e.chk_loc) begin
               chk(int'(fix_addr) == e.addr, {e.req, " fix_addr"}, int'(fix_addr), e.addr);
               chk(int'(fix_bit) == e.bitn, {e.req, " fix_bit"}, int'(fix_bit), e.bitn);
            end
         end
         seen <= seen + 1;
      end
   end

   function automatic logic [31:0] s256(logic [7:0] b, logic [2:0] k);
      logic [10:0] l = {b, k};
      return {10'b0, ~l, l};
   endfunction
   function automatic logic [31:0] s512(logic [8:0] b, logic [2:0] k);
      logic [11:0] l = {b, k};
      return {8'b0, ~l, l};
   endfunction
   function automatic logic [31:0] spg(logic [10:0] w, logic [3:0] k);
      logic [14:0] l = {w, k};
      return {1'b0, ~l, 1'b0, l};
   endfunction

   task automatic clear_syn();
      for (int i = 0; i < 16; i++) begin
         st_arr[i]  = 32'h3C5A_0F96 + 32'(i * 32'h0101_1357);
         syn_arr[i] = 32'h0;
      end
   endtask

   task automatic run_job(input logic [1:0] md, input logic [3:0] cn, input exp_t e,
                          input bit poke_busy);
      int target;
      target = seen + 1;
      sbq.push_back(e);
      @(negedge clk);
      mode_r    = md;
      cnt_r     = cn;
      start     = 1'b1;
      start_cyc = cyc;
      wr_base   = wr_total;
      @(negedge clk);
      start = 1'b0;
      if (poke_busy) begin
         @(negedge clk);
         mode_r = 2'd2;
         cnt_r  = 4'd0;
         start  = 1'b1;
         @(negedge clk);
         start  = 1'b0;
      end
      wait (seen == target);
      repeat (2) @(negedge clk);
   endtask

   task automatic chk_mem(int a, int k, string req);
      logic [7:0] exp_b;
      exp_b = pat(a) ^ (8'h01 << k);
      chk(memrd(a) == exp_b, req, int'(memrd(a)), int'(exp_b));
   endtask

   function automatic exp_t mk(int st, int ad, int bn, int wr, int lat, bit cl, string rq);
      exp_t e;
      e.stat = st; e.addr = ad; e.bitn = bn; e.writes = wr; e.lat = lat;
      e.chk_loc = cl; e.req = rq;
      return e;
   endfunction

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : main
      int s;
      clear_syn();
      repeat (3) @(negedge clk);
      // R12 reset state
      chk(done == 1'b0, "R12 done", int'(done), 0);
      chk(status == 2'd0, "R12 status", int'(status), 0);
      chk(!buf_rd_en && !buf_wr_en, "R12 buffer strobes", int'({buf_rd_en, buf_wr_en}), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R1 clean single sector
      run_job(2'd0, 4'd0, mk(0, 0, 0, 0, 2, 0, "R1"), 0);

      // R2 256-byte mode, error in sector 2
      clear_syn();
      syn_arr[2] = s256(8'h9C, 3'd5);
      run_job(2'd0, 4'd3, mk(1, 12'h29C, 5, 1, 7, 1, "R2"), 0);
      chk_mem(12'h29C, 5, "R9 256 flip");

      // R3 512-byte mode, offset using syndrome bit 11
      clear_syn();
      syn_arr[1] = s512(9'h1A3, 3'd7);
      run_job(2'd1, 4'd1, mk(1, 12'h3A3, 7, 1, 5, 1, "R3"), 0);
      chk_mem(12'h3A3, 7, "R9 512 flip");

      // R4 page mode, odd byte, later sectors junk and ignored
      clear_syn();
      syn_arr[0] = spg(11'h2B1, 4'hB);
      for (int i = 1; i < 16; i++) syn_arr[i] = 32'h7;
      run_job(2'd2, 4'd5, mk(1, 13'h563, 3, 1, 4, 1, "R4"), 0);
      chk_mem(13'h563, 3, "R9 page flip");

      // R5 damaged stored code
      clear_syn();
      syn_arr[0] = 32'h0000_0400;
      run_job(2'd0, 4'd0, mk(2, 0, 0, 0, 2, 0, "R5"), 0);

      // R8 correction then abort keeps location, status 3
      clear_syn();
      syn_arr[0] = s256(8'h11, 3'd0);
      syn_arr[1] = 32'h0000_001F;
      run_job(2'd0, 4'd1, mk(3, 12'h011, 0, 1, 5, 1, "R8"), 0);

      // R7 abort before a correctable sector
      clear_syn();
      syn_arr[0] = 32'h0000_0003;
      syn_arr[1] = s256(8'h77, 3'd1);
      run_job(2'd0, 4'd2, mk(3, 0, 0, 0, 2, 0, "R7"), 0);

      // R6 eleven ones in 512-byte mode is uncorrectable
      clear_syn();
      syn_arr[0] = s256(8'h40, 3'd2);
      run_job(2'd1, 4'd0, mk(3, 0, 0, 0, 2, 0, "R6"), 0);

      // R4 mode 3 behaves as page mode
      clear_syn();
      syn_arr[0] = spg(11'h005, 4'h2);
      run_job(2'd3, 4'd0, mk(1, 13'h00A, 2, 1, 4, 1, "R4 mode3"), 0);
      chk_mem(13'h00A, 2, "R9 mode3 flip");

      // R8 two corrections, last location reported; R11 stray start mid-job
      clear_syn();
      syn_arr[0] = s256(8'h01, 3'd1);
      syn_arr[2] = s256(8'hFE, 3'd6);
      run_job(2'd0, 4'd3, mk(1, 12'h2FE, 6, 2, 9, 1, "R8 R11"), 1);
      chk_mem(12'h001, 1, "R9 first flip");
      chk_mem(12'h2FE, 6, "R9 second flip");
      s = seen;
      repeat (12) @(negedge clk);
      chk(seen == s, "R11 no extra done", seen, s);
      chk(status == 2'd1, "R10 status holds", int'(status), 1);

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule